// File: doc/BRIEF.md
# Sample-Queued Pulse-Width Modulator

This block is a single-channel pulse-width modulator with a small register interface. Software writes a period value and then pushes 16-bit duty samples into a four-entry queue. Each full output period uses the sample at the head of the queue as its high time. A 16-bit counter runs over `period + 2` prescaled counts. An optional repeat setting reuses each sample for 2, 4 or 8 periods before the next one is taken. If the queue is empty when a sample is due, the last sample stays in use.

The count rate comes from one of three tick sources: every core clock, a fast tick input or a slow tick input. A 12-bit prescaler then divides that rate. The output can be driven normally, inverted or held off. A disabled channel always drives 0. Status reports how many samples are queued, whether the queue is empty, period rollover, compare match, and a queue write error. The write error is raised when a sample is pushed into a full queue, and the channel does not run while it is set. A self-clearing soft reset returns every register and the queue to their reset values.

Top module: `pwm_sampler`

## Requirements
- R1: After reset, control reads 0x0000_0000, status reads 0x0000_0008, the sample register reads 0, period reads 0x0000_FFFE, and `pwm_out` is 0.
- R2: The registers are decoded on byte address `bus_addr`: control at 0x00, status at 0x04, sample at 0x0C, period at 0x10. A write takes effect on the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` one clock after the address is presented.
- R3: With a count rate of one per clock and a divide of 1, one output period lasts (period + 2) clocks. The output is active for `duty` clocks of each period. A duty of period + 2 or more keeps it active all period, and a duty of 0 never makes it active.
- R4: Control bits 15:4 hold the prescaler field. Each count lasts (field + 1) source ticks.
- R5: Writing 0xFFFF to the period register stores 0xFFFE, which reads back as 0xFFFE. Any other value is stored as written.
- R6: Control bits 19:18 select the output mode while enabled: 0 drives the active level, 1 drives its inverse, and 2 or 3 hold the output at 0.
- R7: While control bit 0 (enable) is 0, `pwm_out` is 0 in every output mode.
- R8: The sample queue holds 4 entries. Status bits 2:0 give the number of queued samples (0 to 4), and status bit 3 is 1 exactly when the queue is empty.
- R9: A sample write while the queue holds 4 entries is dropped and sets status bit 6. While bit 6 is set, the counter does not run, even when enabled. Writing 1 to status bit 6 clears it.
- R10: Control bits 2:1 give the repeat code. Codes 0, 1, 2 and 3 use each sample for 1, 2, 4 or 8 periods. When the queue is empty at a sample change, the previous sample is kept.
- R11: Control bits 17:16 pick the count source: 0 none (counter stopped, output inactive), 1 every clock, 2 `tick_fast`, 3 `tick_slow`.
- R12: Status bit 4 is set at each period end and status bit 5 is set when the counter equals the duty. Writing 1 to either bit clears that bit and leaves the other.
- R13: Writing 1 to control bit 3 starts a soft reset. Control bit 3 then reads 1 for SWR_CYCLES clocks and clears by itself. The queue and all registers return to their R1 values, and register writes during the reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_fast | input | 1 | Count enable for fast source (code 2) |
| tick_slow | input | 1 | Count enable for slow source (code 3) |
| pwm_out | output | 1 | Registered modulator output |

## Verification
The hardest state to reach is the queue write error with the channel enabled. To get there, four samples are queued while the channel is disabled and a fifth is pushed. Enabling the channel must then leave the output quiet and the queue untouched. Clearing the error must let the counter start and use up the queued samples. The repeat modes are checked with a queue ending in a zero-duty sample. The total active time from enable onward then depends only on the repeat count, so it can be checked without aligning to a period boundary.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [4:0] OFS_CTRL   = 5'h00;
  localparam logic [4:0] OFS_STAT   = 5'h04;
  localparam logic [4:0] OFS_SAMPLE = 5'h0C;
  localparam logic [4:0] OFS_PERIOD = 5'h10;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_INVERT = 2'd1,
    MODE_OFF    = 2'd2,
    MODE_OFF2   = 2'd3
  } out_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BUS  = 2'd1,
    SRC_FAST = 2'd2,
    SRC_SLOW = 2'd3
  } src_sel_e;
endpackage

// File: rtl/pwm_fifo.sv
module pwm_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic full, do_push, do_pop;

  assign full     = (count == CW'(DEPTH));
  assign do_push  = push && !full;
  assign do_pop   = pop && (count != '0);
  assign overflow = push && full;
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  a_r8_fifo_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (pop && !clr) |-> count != '0);
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          src_en,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] pc;

  assign tick = run && src_en && (pc == div);

  always_ff @(posedge clk) begin
    if (rst || !run) pc <= '0;
    else if (src_en) pc <= (pc == div) ? '0 : pc + 1'b1;
  end

  a_r11_tick_needs_source: assert property (@(posedge clk) disable iff (rst)
    tick |-> (run && src_en));
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [DW-1:0] period,
  input  logic [1:0]    rpt,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic          pop,
  output logic          running,
  output logic          active,
  output logic          rov_evt,
  output logic          cmp_evt,
  output logic [DW-1:0] duty
);
  localparam int CTW = DW + 1;

  logic [CTW-1:0] cnt, last;
  logic [2:0] rep, rep_lim;
  logic wrap;

  assign last    = CTW'(period) + 1'b1;
  assign rep_lim = 3'((4'd1 << rpt) - 4'd1);
  assign wrap    = running && tick && (cnt >= last);
  assign rov_evt = wrap;
  assign cmp_evt = running && tick && (cnt == CTW'(duty));
  assign pop     = run && smp_valid &&
                   (!running || (wrap && rep >= rep_lim));
  assign active  = running && (cnt < CTW'(duty));

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt <= '0;
      rep <= '0;
      duty <= '0;
    end else if (!run) begin
      running <= 1'b0;
      cnt <= '0;
      rep <= '0;
    end else if (!running) begin
      running <= 1'b1;
      cnt <= '0;
      rep <= '0;
      if (smp_valid) duty <= smp_data;
    end else if (tick) begin
      if (wrap) begin
        cnt <= '0;
        if (rep >= rep_lim) begin
          rep <= '0;
          if (smp_valid) duty <= smp_data;
        end else begin
          rep <= rep + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r12_rollover_restarts: assert property (@(posedge clk) disable iff (rst)
    (rov_evt && run) |=> cnt == '0);
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    ($past(running) && running && !$past(tick)) |-> $stable(cnt));
endmodule

// File: rtl/pwm_sampler.sv
module pwm_sampler #(
  parameter int DW         = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int PW         = 12,
  parameter int SWR_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_fast,
  input  logic        tick_slow,
  output logic        pwm_out
);
  import pwm_pkg::*;

  localparam int CW  = $clog2(FIFO_DEPTH + 1);
  localparam int SCW = $clog2(SWR_CYCLES + 1);
  localparam logic [DW-1:0] PER_MAX = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0] PER_ALL = {DW{1'b1}};

  logic [27:0]    ctrl_q;
  logic [DW-1:0]  period_q;
  logic           fwe_q, rov_q, cmp_q;
  logic [SCW-1:0] swr_cnt;
  logic           swr_busy;

  logic wr_ctrl, wr_stat, wr_smp, wr_per;
  logic ctl_en;
  logic [1:0] ctl_rpt;
  logic [PW-1:0] ctl_div;
  src_sel_e ctl_src;
  out_mode_e ctl_mode;

  logic [DW-1:0] fifo_head, duty_cur;
  logic [CW-1:0] fifo_cnt;
  logic fifo_ovf, fifo_pop;
  logic run, src_en, tick, core_running, active, rov_evt, cmp_evt;

  assign swr_busy = (swr_cnt != '0);
  assign wr_ctrl  = bus_wr && !swr_busy && bus_addr == OFS_CTRL;
  assign wr_stat  = bus_wr && !swr_busy && bus_addr == OFS_STAT;
  assign wr_smp   = bus_wr && !swr_busy && bus_addr == OFS_SAMPLE;
  assign wr_per   = bus_wr && !swr_busy && bus_addr == OFS_PERIOD;

  assign ctl_en   = ctrl_q[0];
  assign ctl_rpt  = ctrl_q[2:1];
  assign ctl_div  = ctrl_q[4 +: PW];
  assign ctl_src  = src_sel_e'(ctrl_q[17:16]);
  assign ctl_mode = out_mode_e'(ctrl_q[19:18]);

  always_comb begin
    unique case (ctl_src)
      SRC_BUS:  src_en = 1'b1;
      SRC_FAST: src_en = tick_fast;
      SRC_SLOW: src_en = tick_slow;
      default:  src_en = 1'b0;
    endcase
  end

  assign run = ctl_en && !fwe_q && !swr_busy && (ctl_src != SRC_NONE);

  // soft reset sequencer
  always_ff @(posedge clk) begin
    if (rst) swr_cnt <= '0;
    else if (swr_busy) swr_cnt <= swr_cnt - 1'b1;
    else if (wr_ctrl && bus_wdata[3]) swr_cnt <= SCW'(SWR_CYCLES);
  end

  // register file
  always_ff @(posedge clk) begin
    if (rst || swr_busy) begin
      ctrl_q   <= '0;
      period_q <= PER_MAX;
      fwe_q    <= 1'b0;
      rov_q    <= 1'b0;
      cmp_q    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= {bus_wdata[27:4], 1'b0, bus_wdata[2:0]};
      if (wr_per)  period_q <= (bus_wdata[DW-1:0] == PER_ALL) ? PER_MAX : bus_wdata[DW-1:0];
      fwe_q <= fifo_ovf | (fwe_q & ~(wr_stat & bus_wdata[6]));
      rov_q <= rov_evt  | (rov_q & ~(wr_stat & bus_wdata[4]));
      cmp_q <= cmp_evt  | (cmp_q & ~(wr_stat & bus_wdata[5]));
    end
  end

  pwm_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(swr_busy),
    .push(wr_smp), .push_data(bus_wdata[DW-1:0]),
    .pop(fifo_pop), .head(fifo_head), .count(fifo_cnt), .overflow(fifo_ovf)
  );

  pwm_prescaler #(.PW(PW)) u_pre (
    .clk(clk), .rst(rst), .run(run), .src_en(src_en), .div(ctl_div), .tick(tick)
  );

  pwm_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst || swr_busy), .run(run), .tick(tick),
    .period(period_q), .rpt(ctl_rpt),
    .smp_valid(fifo_cnt != '0), .smp_data(fifo_head),
    .pop(fifo_pop), .running(core_running), .active(active),
    .rov_evt(rov_evt), .cmp_evt(cmp_evt), .duty(duty_cur)
  );

  // registered output and read data
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (!ctl_en) pwm_out <= 1'b0;
      else begin
        unique case (ctl_mode)
          MODE_NORMAL: pwm_out <= active;
          MODE_INVERT: pwm_out <= ~active;
          default:     pwm_out <= 1'b0;
        endcase
      end
      unique case (bus_addr)
        OFS_CTRL:   bus_rdata <= {4'b0, ctrl_q[27:4], swr_busy, ctrl_q[2:0]};
        OFS_STAT:   bus_rdata <= 32'({fwe_q, cmp_q, rov_q, (fifo_cnt == '0), 3'(fifo_cnt)});
        OFS_SAMPLE: bus_rdata <= 32'(duty_cur);
        OFS_PERIOD: bus_rdata <= 32'(period_q);
        default:    bus_rdata <= '0;
      endcase
    end
  end

  a_r7_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !$past(ctl_en) |-> !pwm_out);
  a_r9_no_run_on_error: assert property (@(posedge clk) disable iff (rst)
    $past(fwe_q) |-> !core_running);
  a_r5_period_clamped: assert property (@(posedge clk) disable iff (rst)
    period_q != PER_ALL);
  a_r13_reset_flushes: assert property (@(posedge clk) disable iff (rst)
    $past(swr_busy) |-> (fifo_cnt == '0 && !core_running));
endmodule

// File: tb/pwm_sampler_test.sv
module pwm_sampler_test;
  logic clk = 0, rst = 1, bus_wr = 0, tick_fast = 1, tick_slow = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic pwm_out;
  int n_run = 0, n_fail = 0;

  pwm_sampler uut (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .pwm_out(pwm_out));

  always #4 clk = ~clk;

  initial begin
    forever begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        tick_slow = (k == 3);
      end
    end
  end

  // {period, duty, prescale, mode, src, window, expected active clocks}
  localparam logic [79:0] VEC [10] = '{
    {16'd8, 16'd3,  12'd0, 2'd0, 2'd1, 16'd40,  16'd12},
    {16'd8, 16'd3,  12'd0, 2'd1, 2'd1, 16'd40,  16'd28},
    {16'd8, 16'd3,  12'd0, 2'd2, 2'd1, 16'd40,  16'd0},
    {16'd6, 16'd5,  12'd2, 2'd0, 2'd1, 16'd96,  16'd60},
    {16'd0, 16'd1,  12'd0, 2'd0, 2'd1, 16'd8,   16'd4},
    {16'd4, 16'd20, 12'd0, 2'd0, 2'd1, 16'd24,  16'd24},
    {16'd4, 16'd0,  12'd0, 2'd0, 2'd1, 16'd24,  16'd0},
    {16'd8, 16'd3,  12'd0, 2'd0, 2'd2, 16'd40,  16'd12},
    {16'd8, 16'd3,  12'd0, 2'd0, 2'd3, 16'd160, 16'd48},
    {16'd8, 16'd3,  12'd0, 2'd0, 2'd0, 16'd40,  16'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic count_high(input int w, output int h);
    h = 0;
    for (int i = 0; i < w; i++) begin
      @(posedge clk);
      #1 if (pwm_out) h++;
    end
  endtask

  task automatic soft_reset();
    logic [31:0] v;
    wr(5'h00, 32'h8);
    for (int i = 0; i < 20; i++) begin
      rd(5'h00, v);
      if (!v[3]) break;
    end
  endtask

  initial begin
    logic [31:0] v;
    int h;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset values
    rd(5'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(5'h04, v); chk("R1 status", v, 32'h8);
    rd(5'h0C, v); chk("R1 sample", v, 32'h0);
    rd(5'h10, v); chk("R1 period", v, 32'hFFFE);
    chk("R1 out", 32'(pwm_out), 32'h0);

    // R3 R4 R6 R11 table walk
    foreach (VEC[i]) begin
      soft_reset();
      wr(5'h10, 32'(VEC[i][79:64]));
      wr(5'h0C, 32'(VEC[i][63:48]));
      wr(5'h00, 32'h1 | (32'(VEC[i][47:36]) << 4) | (32'(VEC[i][35:34]) << 18) |
                (32'(VEC[i][33:32]) << 16));
      repeat (100) @(posedge clk);
      count_high(int'(VEC[i][31:16]), h);
      chk($sformatf("R3/R4/R6/R11 vector %0d", i), 32'(h), 32'(VEC[i][15:0]));
    end

    // R7 disabled inverted output is low
    soft_reset();
    wr(5'h10, 32'd8); wr(5'h0C, 32'd3);
    wr(5'h00, 32'h0005_0000);
    repeat (20) @(posedge clk);
    count_high(40, h); chk("R7 disabled inverted", 32'(h), 32'd0);

    // R10 repeat codes, queue 3,5,0
    for (int r = 0; r < 4; r++) begin
      soft_reset();
      wr(5'h10, 32'd6);
      wr(5'h0C, 32'd3); wr(5'h0C, 32'd5); wr(5'h0C, 32'd0);
      @(negedge clk);
      bus_wr = 1; bus_addr = 5'h00; bus_wdata = 32'h0001_0001 | (32'(r) << 1);
      @(negedge clk); bus_wr = 0;
      count_high(400, h);
      chk($sformatf("R10 repeat code %0d", r), 32'(h), 32'(8 << r));
    end

    // R8 R9 queue fill and write error
    soft_reset();
    wr(5'h10, 32'd8);
    wr(5'h0C, 32'd3); wr(5'h0C, 32'd3); wr(5'h0C, 32'd3);
    rd(5'h04, v); chk("R8 three queued", v, 32'h3);
    wr(5'h0C, 32'd3);
    rd(5'h04, v); chk("R8 four queued", v, 32'h4);
    wr(5'h0C, 32'd9);
    rd(5'h04, v); chk("R9 overflow flag", v, 32'h44);
    wr(5'h00, 32'h0001_0001);
    repeat (20) @(posedge clk);
    count_high(40, h); chk("R9 held while error", 32'(h), 32'd0);
    rd(5'h04, v); chk("R9 queue untouched", v, 32'h44);
    wr(5'h04, 32'h40);
    repeat (100) @(posedge clk);
    count_high(40, h); chk("R9 runs after clear", 32'(h), 32'd12);
    rd(5'h0C, v); chk("R9 dropped sample absent", v, 32'd3);

    // R12 status flags W1C
    wr(5'h00, 32'h0001_0000);
    rd(5'h04, v); chk("R12 rov and cmp set", v, 32'h38);
    wr(5'h04, 32'h10);
    rd(5'h04, v); chk("R12 rov cleared only", v, 32'h28);
    wr(5'h04, 32'h20);
    rd(5'h04, v); chk("R12 cmp cleared", v, 32'h08);

    // R5 period clamp
    wr(5'h10, 32'hFFFF);
    rd(5'h10, v); chk("R5 clamp", v, 32'hFFFE);
    wr(5'h10, 32'h1234);
    rd(5'h10, v); chk("R5 plain value", v, 32'h1234);

    // R2 R13 soft reset
    wr(5'h0C, 32'd7);
    wr(5'h00, 32'h8);
    rd(5'h00, v); chk("R13 busy bit", v, 32'h8);
    wr(5'h10, 32'h55);
    repeat (10) @(posedge clk);
    rd(5'h00, v); chk("R13 self clear", v, 32'h0);
    rd(5'h10, v); chk("R13 write ignored, period reset", v, 32'hFFFE);
    rd(5'h04, v); chk("R13 queue flushed", v, 32'h8);
    wr(5'h00, 32'h0004_0006);
    rd(5'h00, v); chk("R2 ctrl readback", v, 32'h0004_0006);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule